// File: doc/BRIEF.md
# Memory-Mapped Storage Command Front End

This block sits between user logic and a storage transport engine. User logic issues fixed-size block commands through a small memory-mapped request port. The port has a write strobe, a read strobe, a block address and a 128-bit data bus. Every command moves one 8 KiB block, which is `BEATS` beats of 128 bits. A write is offered together with its first data beat, and the remaining beats follow on the same port. A single wait-request output throttles the command and its data together. Whenever that output is high, the user holds the strobe, the address and the current data beat unchanged.

Each accepted command is forwarded to the downstream engine as a record that carries its type, its block address and a tag. The record is exchanged with a valid/ready handshake. Write data beats are forwarded as a valid-qualified stream with a last-beat marker. The engine reports each finished command with a completion strobe and a flag that says whether the command was a read. The front end uses these reports to keep count of the commands in flight and of the read-buffer credit that is still in use. When the queue is full, or when a read finds no free buffer credit, the front end stalls the user. After every accepted command it also holds the user off for a fixed pre-processing interval.

Top module: `mm_cmd_front`

## Requirements
- R1: In the idle state, a command with exactly one strobe high and an address whose low 4 bits are zero is accepted at the first clock edge where `wait_req` is low. For a write, data beat 0 is accepted in the same cycle. After acceptance, one record appears on the `cmd_*` port. In that record `cmd_is_rd` is 1 for a read and 0 for a write, and `cmd_addr` is the request address.
- R2: A write moves exactly `BEATS` beats (512 by default). The beats appear on `wdat_data` in the order they were offered, one cycle after each accepted beat. `wdat_last` is high only on the final beat. A beat is taken only in a cycle where `req_wr` is high and `wait_req` is low, so dropping `req_wr` pauses the transfer without losing data.
- R3: After each acceptance, `wait_req` stays high for at least `PRE_CYC` cycles (6 by default). It is exactly `PRE_CYC` cycles when the downstream record is taken at once.
- R4: After the pre-processing stall of a write, `wait_req` stays low through the final beat, including any cycles in which the user pauses.
- R5: At most `QDEPTH` commands (128 by default) are outstanding. While that many are queued, `wait_req` is high for any request and nothing is accepted. For a write, the stall therefore appears after its final beat. A completion frees one slot.
- R6: Outstanding reads are limited to 2^`RD_DEPTH` (8 to 128; 8 by default). A read that finds no free credit sees `wait_req` high and is not accepted. A write is still accepted in that situation. A completion with `cmpl_rd` high returns one read credit.
- R7: If both strobes are high together, or a strobe is high with a nonzero low 4 bits of address, the block rejects the request. `wait_req` is high, nothing is accepted, and `proto_err` is high in the next cycle.
- R8: `busy` rises in the cycle after an acceptance. It falls only after the command in progress has finished its stall and data and every queued command has completed.
- R9: A record stays on `cmd_valid` with all fields stable until `cmd_ready` is seen. While it waits, the pre-processing stall is extended. `cmd_tag` starts at 0 after reset, rises by one per accepted command and wraps modulo 128.
- R10: An acceptance and a completion in the same cycle leave the outstanding count unchanged.
- R11: After reset, `wait_req`, `busy`, `cmd_valid`, `wdat_valid` and `proto_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write command / write data strobe |
| req_rd | input | 1 | Read command strobe |
| req_addr | input | 48 | Block address in 512-byte units, low 4 bits zero |
| req_wdata | input | 128 | Write data beat |
| wait_req | output | 1 | High: command or data beat not taken this cycle |
| busy | output | 1 | A command is in progress or outstanding |
| proto_err | output | 1 | One-cycle flag for a rejected malformed request |
| cmd_valid | output | 1 | Downstream command record valid |
| cmd_ready | input | 1 | Downstream engine takes the record |
| cmd_is_rd | output | 1 | Record type: 1 read, 0 write |
| cmd_addr | output | 48 | Record block address |
| cmd_tag | output | 7 | Record tag |
| wdat_valid | output | 1 | Forwarded write beat valid |
| wdat_data | output | 128 | Forwarded write beat |
| wdat_last | output | 1 | Final beat of a write |
| cmpl_valid | input | 1 | One command completed downstream |
| cmpl_rd | input | 1 | The completed command was a read |

## Verification
The hardest case to reach is a full queue, where the front end must stall a request with no help from the read-credit limit. Reaching it takes more than a hundred outstanding commands. The stimulus first exhausts the read credit and shows that writes still pass. It then fills the remaining slots with writes, frees a single slot, and lands an acceptance and a completion on the same edge. A count that drifted at that edge shows up as a wrong stall on the next write. A downstream engine that holds back `cmd_ready` is emulated to stretch the stall and check that the record is held.

// File: rtl/mmcf_pkg.sv
package mmcf_pkg;
   localparam int ADDR_W     = 48;
   localparam int DATA_W     = 128;
   localparam int TAG_W      = 7;
   localparam int ALIGN_BITS = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA
   } seq_st_e;

   typedef struct packed {
      logic              is_rd;
      logic [ADDR_W-1:0] addr;
      logic [TAG_W-1:0]  tag;
   } cmd_rec_t;
endpackage

// File: rtl/mmcf_occ_ctr.sv
module mmcf_occ_ctr #(
   parameter  int LIMIT = 128,
   localparam int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic full,
   output logic empty
);
   logic [CW-1:0] cnt;
   logic          inc_ok, dec_ok;

   assign full   = (cnt == CW'(LIMIT));
   assign empty  = (cnt == '0);
   assign inc_ok = inc && !full;
   assign dec_ok = dec && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (inc_ok && !dec_ok) cnt <= cnt + 1'b1;
      else if (dec_ok && !inc_ok) cnt <= cnt - 1'b1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full && inc && !dec |=> full); // R5
endmodule

// File: rtl/mmcf_seq.sv
module mmcf_seq import mmcf_pkg::*; #(
   parameter  int PRE_CYC = 6,
   parameter  int BEATS   = 512,
   localparam int PW      = $clog2(PRE_CYC + 1),
   localparam int BW      = $clog2(BEATS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_wr,
   input  logic                  req_rd,
   input  logic [ALIGN_BITS-1:0] addr_lo,
   input  logic                  q_full,
   input  logic                  rd_full,
   input  logic                  rec_pending,
   output logic                  wait_req,
   output logic                  acc,
   output logic                  beat_ok,
   output logic                  beat_last,
   output logic                  proto_bad,
   output logic                  idle
);
   seq_st_e       st, st_nxt;
   logic [PW-1:0] pre_cnt;
   logic [BW-1:0] beat_idx;
   logic          cur_wr;
   logic          any_req, both, misal, bad, blocked, pre_end;

   always_comb begin
      any_req   = req_wr | req_rd;
      both      = req_wr & req_rd;
      misal     = |addr_lo;
      bad       = both | (any_req & misal);
      blocked   = q_full | (req_rd & rd_full) | bad;
      pre_end   = (pre_cnt == '0) && !rec_pending;
      st_nxt    = st;
      wait_req  = 1'b1;
      acc       = 1'b0;
      beat_ok   = 1'b0;
      beat_last = 1'b0;
      unique case (st)
         ST_IDLE: begin
            wait_req  = blocked;
            acc       = any_req & !blocked;
            beat_ok   = acc & req_wr;
            beat_last = beat_ok && (BEATS == 1);
            if (acc) st_nxt = ST_PRE;
         end
         ST_PRE: begin
            if (pre_end) st_nxt = (cur_wr && (BEATS > 1)) ? ST_DATA : ST_IDLE;
         end
         ST_DATA: begin
            wait_req  = 1'b0;
            beat_ok   = req_wr & !req_rd;
            beat_last = beat_ok && (beat_idx == BW'(BEATS - 1));
            if (beat_last) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   assign proto_bad = both | ((st == ST_IDLE) & any_req & misal);
   assign idle      = (st == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pre_cnt  <= '0;
         beat_idx <= '0;
         cur_wr   <= 1'b0;
      end else begin
         st <= st_nxt;
         if (acc) begin
            pre_cnt  <= PW'(PRE_CYC - 1);
            beat_idx <= BW'(1);
            cur_wr   <= req_wr;
         end else begin
            if (st == ST_PRE && pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
            if (st == ST_DATA && beat_ok)      beat_idx <= beat_idx + 1'b1;
         end
      end
   end

   // checker: length of the current pre-processing stall
   logic [PW-1:0] chk_run;
   always_ff @(posedge clk) begin
      if (!rst_n || acc)                                chk_run <= '0;
      else if (st == ST_PRE && chk_run != PW'(PRE_CYC)) chk_run <= chk_run + 1'b1;
   end

   AST_PRE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> wait_req); // R3
   AST_PRE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE && st_nxt != ST_PRE) |-> chk_run >= PW'(PRE_CYC - 1)); // R3
   AST_BOTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_rd) |-> !acc && !beat_ok); // R7
   AST_DATA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && !beat_last) |=> !wait_req); // R4
endmodule

// File: rtl/mmcf_cmd_out.sv
module mmcf_cmd_out import mmcf_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rd,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              out_ready,
   output logic              out_valid,
   output cmd_rec_t          out_rec
);
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q     <= '0;
         out_valid <= 1'b0;
         out_rec   <= '0;
      end else if (load) begin
         out_rec   <= '{is_rd: ld_rd, addr: ld_addr, tag: tag_q};
         out_valid <= 1'b1;
         tag_q     <= tag_q + 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(out_valid && !out_ready)); // R9
   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_rec)); // R9
endmodule

// File: rtl/mm_cmd_front.sv
module mm_cmd_front import mmcf_pkg::*; #(
   parameter  int QDEPTH   = 128,
   parameter  int RD_DEPTH = 3,
   parameter  int PRE_CYC  = 6,
   parameter  int BEATS    = 512,
   localparam int RD_LIMIT = 1 << RD_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_rd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              wait_req,
   output logic              busy,
   output logic              proto_err,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_is_rd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [TAG_W-1:0]  cmd_tag,
   output logic              wdat_valid,
   output logic [DATA_W-1:0] wdat_data,
   output logic              wdat_last,
   input  logic              cmpl_valid,
   input  logic              cmpl_rd
);
   if (RD_DEPTH < 3 || RD_DEPTH > 7) begin : g_bad_rd
      $error("RD_DEPTH must lie in 3..7");
   end
   if (QDEPTH < 1 || QDEPTH > (1 << TAG_W)) begin : g_bad_q
      $error("QDEPTH must lie in 1..2**TAG_W");
   end
   if (PRE_CYC < 1 || BEATS < 1) begin : g_bad_len
      $error("PRE_CYC and BEATS must be at least 1");
   end

   logic     q_full, q_empty, rd_full, rd_empty;
   logic     acc, beat_ok, beat_last, proto_bad, seq_idle;
   cmd_rec_t rec;

   mmcf_occ_ctr #(.LIMIT(QDEPTH)) u_qcnt (
      .clk(clk), .rst_n(rst_n), .inc(acc), .dec(cmpl_valid),
      .full(q_full), .empty(q_empty)
   );

   if (RD_LIMIT < QDEPTH) begin : g_rd_credit
      mmcf_occ_ctr #(.LIMIT(RD_LIMIT)) u_rcnt (
         .clk(clk), .rst_n(rst_n), .inc(acc & req_rd), .dec(cmpl_valid & cmpl_rd),
         .full(rd_full), .empty(rd_empty)
      );
   end else begin : g_rd_by_queue
      assign rd_full  = 1'b0;
      assign rd_empty = q_empty;
   end

   mmcf_seq #(.PRE_CYC(PRE_CYC), .BEATS(BEATS)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .addr_lo(req_addr[ALIGN_BITS-1:0]), .q_full(q_full), .rd_full(rd_full),
      .rec_pending(cmd_valid & !cmd_ready), .wait_req(wait_req), .acc(acc),
      .beat_ok(beat_ok), .beat_last(beat_last), .proto_bad(proto_bad), .idle(seq_idle)
   );

   mmcf_cmd_out u_out (
      .clk(clk), .rst_n(rst_n), .load(acc), .ld_rd(req_rd), .ld_addr(req_addr),
      .out_ready(cmd_ready), .out_valid(cmd_valid), .out_rec(rec)
   );

   assign cmd_is_rd = rec.is_rd;
   assign cmd_addr  = rec.addr;
   assign cmd_tag   = rec.tag;
   assign busy      = !seq_idle || !q_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         proto_err  <= 1'b0;
         wdat_valid <= 1'b0;
         wdat_last  <= 1'b0;
         wdat_data  <= '0;
      end else begin
         proto_err  <= proto_bad;
         wdat_valid <= beat_ok;
         wdat_last  <= beat_last;
         if (beat_ok) wdat_data <= req_wdata;
      end
   end

   AST_QUEUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> !q_full); // R5
   AST_RD_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_rd) |-> !rd_full); // R6
   AST_RD_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> rd_empty); // R6
   AST_BUSY_ON: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy); // R8
   AST_PROTO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_rd) |=> proto_err); // R7
endmodule

// File: tb/mm_cmd_front_tb_top.sv
module mm_cmd_front_tb_top;
   localparam int BEATS = 16;
   localparam int PRE   = 6;
   localparam int QD    = 128;
   localparam int RDL   = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_wr = 1'b0, req_rd = 1'b0;
   logic [47:0]  req_addr = '0;
   logic [127:0] req_wdata = '0;
   logic         wait_req, busy, proto_err, cmd_valid, cmd_is_rd;
   logic         cmd_ready = 1'b1;
   logic [47:0]  cmd_addr;
   logic [6:0]   cmd_tag;
   logic         wdat_valid, wdat_last;
   logic [127:0] wdat_data;
   logic         cmpl_valid = 1'b0, cmpl_rd = 1'b0;

   always #5 clk = ~clk;

   mm_cmd_front #(.QDEPTH(QD), .RD_DEPTH(3), .PRE_CYC(PRE), .BEATS(BEATS)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
      .req_wdata(req_wdata), .wait_req(wait_req), .busy(busy), .proto_err(proto_err),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_rd(cmd_is_rd),
      .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .wdat_valid(wdat_valid),
      .wdat_data(wdat_data), .wdat_last(wdat_last), .cmpl_valid(cmpl_valid),
      .cmpl_rd(cmpl_rd)
   );

   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;
   logic [6:0] exp_tag = '0;
   logic [55:0]  exp_cmd[$];
   logic [128:0] exp_dat[$];

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] mkdat(input logic [47:0] a, input int b);
      return {a, 48'h5A5A_C3C3_0F0F, 32'(b)};
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cmd_valid && cmd_ready) begin
            if (exp_cmd.size() == 0) chk(1'b0, "R1 unexpected record", {cmd_is_rd, cmd_addr, cmd_tag}, 0);
            else begin
               logic [55:0] e;
               e = exp_cmd.pop_front();
               chk({cmd_is_rd, cmd_addr, cmd_tag} == e, "R1/R9 record", {cmd_is_rd, cmd_addr, cmd_tag}, e);
            end
         end
         if (wdat_valid) begin
            if (exp_dat.size() == 0) chk(1'b0, "R2 unexpected beat", wdat_data, 0);
            else begin
               logic [128:0] d;
               d = exp_dat.pop_front();
               chk({wdat_last, wdat_data} == d, "R2 beat", {wdat_last, wdat_data}, d);
            end
         end
      end
   end

   task automatic do_cmd(input bit rd, input logic [47:0] a, input bit with_cmpl,
                         input bit c_rd, input int pause_at, output int stall,
                         output int dwait);
      stall = 0;
      dwait = 0;
      @(negedge clk);
      req_rd = rd; req_wr = !rd; req_addr = a; req_wdata = mkdat(a, 0);
      #1;
      while (wait_req) begin @(negedge clk); #1; end
      if (with_cmpl) begin cmpl_valid = 1'b1; cmpl_rd = c_rd; end
      @(posedge clk); #1;
      cmpl_valid = 1'b0;
      exp_cmd.push_back({rd, a, exp_tag});
      exp_tag++;
      if (!rd) exp_dat.push_back({(BEATS == 1), mkdat(a, 0)});
      if (rd || BEATS == 1) begin
         req_rd = 1'b0; req_wr = 1'b0;
         @(negedge clk); #1;
         while (wait_req) begin stall++; @(negedge clk); #1; end
      end else begin
         for (int b = 1; b < BEATS; b++) begin
            @(negedge clk);
            if (b == pause_at) begin
               req_wr = 1'b0;
               repeat (3) begin #1; if (wait_req) dwait++; @(negedge clk); end
               req_wr = 1'b1;
            end
            req_wdata = mkdat(a, b);
            #1;
            while (wait_req) begin
               if (b == 1) stall++; else dwait++;
               @(negedge clk); #1;
            end
            @(posedge clk); #1;
            exp_dat.push_back({(b == BEATS - 1), mkdat(a, b)});
         end
         req_wr = 1'b0;
      end
   endtask

   task automatic attempt(input bit rd, input logic [47:0] a, input int ncyc, input string tag);
      int hi = 0;
      @(negedge clk);
      req_rd = rd; req_wr = !rd; req_addr = a; req_wdata = mkdat(a, 0);
      for (int i = 0; i < ncyc; i++) begin #1; if (wait_req) hi++; @(negedge clk); end
      req_rd = 1'b0; req_wr = 1'b0;
      chk(hi == ncyc, tag, hi, ncyc);
   endtask

   task automatic cmpl(input bit rd);
      @(negedge clk);
      cmpl_valid = 1'b1; cmpl_rd = rd;
      @(posedge clk); #1;
      cmpl_valid = 1'b0; cmpl_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      finish_run();
   end

   initial begin
      int st, dw;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!wait_req && !busy && !cmd_valid && !wdat_valid && !proto_err, "R11 reset",
          {wait_req, busy, cmd_valid, wdat_valid, proto_err}, 0);

      // R1 R3 R4 plain write
      do_cmd(1'b0, 48'h10, 1'b0, 1'b0, 0, st, dw);
      chk(st == PRE, "R3 write stall", st, PRE);
      chk(dw == 0, "R4 write data wait", dw, 0);
      chk(busy, "R8 busy after write", busy, 1);

      // R1 R3 read
      do_cmd(1'b1, 48'h20, 1'b0, 1'b0, 0, st, dw);
      chk(st == PRE, "R3 read stall", st, PRE);

      // R2 R4 write with a pause
      do_cmd(1'b0, 48'h1230, 1'b0, 1'b0, 7, st, dw);
      chk(dw == 0, "R4 pause keeps wait low", dw, 0);

      // R7 both strobes
      @(negedge clk);
      req_wr = 1'b1; req_rd = 1'b1; req_addr = 48'h40;
      #1 chk(wait_req, "R7 both strobes wait", wait_req, 1);
      @(posedge clk); #1;
      req_wr = 1'b0; req_rd = 1'b0;
      chk(proto_err, "R7 proto_err on both", proto_err, 1);
      // R7 misaligned address
      @(negedge clk);
      req_rd = 1'b1; req_addr = 48'h21;
      #1 chk(wait_req, "R7 misaligned wait", wait_req, 1);
      @(posedge clk); #1;
      req_rd = 1'b0;
      chk(proto_err, "R7 proto_err on misaligned", proto_err, 1);
      repeat (3) @(negedge clk);
      chk(!cmd_valid && exp_cmd.size() == 0, "R7 nothing accepted", cmd_valid, 0);

      // R9 downstream holds ready low
      cmd_ready = 1'b0;
      fork
         do_cmd(1'b1, 48'h7770, 1'b0, 1'b0, 0, st, dw);
         begin
            repeat (8) @(negedge clk);
            chk(cmd_valid && cmd_addr == 48'h7770 && cmd_is_rd, "R9 record held",
                {cmd_valid, cmd_addr}, {1'b1, 48'h7770});
            repeat (4) @(negedge clk);
            cmd_ready = 1'b1;
         end
      join
      chk(st > PRE, "R9 stall stretched", st, PRE + 1);

      // R8 drain: 2 writes, 2 reads
      cmpl(1'b0); cmpl(1'b1); cmpl(1'b0);
      chk(busy, "R8 busy with one left", busy, 1);
      cmpl(1'b1);
      chk(!busy, "R8 busy low when drained", busy, 0);

      // R6 read credit
      for (int i = 0; i < RDL; i++) do_cmd(1'b1, 48'(32'h100 + i * 16), 1'b0, 1'b0, 0, st, dw);
      attempt(1'b1, 48'h900, 10, "R6 read blocked without credit");
      do_cmd(1'b0, 48'hA00, 1'b0, 1'b0, 0, st, dw);
      chk(st == PRE, "R6 write passes with no read credit", st, PRE);
      cmpl(1'b1);
      do_cmd(1'b1, 48'h900, 1'b0, 1'b0, 0, st, dw);
      chk(st == PRE, "R6 read after credit return", st, PRE);

      // R5 fill the queue (9 outstanding now)
      for (int i = 0; i < QD - 9; i++) do_cmd(1'b0, 48'(32'h10000 + i * 16), 1'b0, 1'b0, 0, st, dw);
      attempt(1'b0, 48'hB00, 10, "R5 write blocked when full");
      attempt(1'b1, 48'hB10, 5, "R5 read blocked when full");
      cmpl(1'b0);
      // R10 accept and completion together: count stays at QD-1
      do_cmd(1'b0, 48'hC00, 1'b1, 1'b0, 0, st, dw);
      do_cmd(1'b0, 48'hC10, 1'b0, 1'b0, 0, st, dw);
      chk(st == PRE, "R10 slot still free after same-cycle pair", st, PRE);
      attempt(1'b0, 48'hC20, 10, "R10 full again after one more");

      // drain all, R8
      for (int i = 0; i < RDL; i++) cmpl(1'b1);
      for (int i = 0; i < QD - RDL - 1; i++) cmpl(1'b0);
      chk(busy, "R8 busy before last completion", busy, 1);
      cmpl(1'b0);
      chk(!busy, "R8 idle after full drain", busy, 0);

      repeat (3) @(negedge clk);
      chk(exp_cmd.size() == 0 && exp_dat.size() == 0, "R1/R2 scoreboard empty",
          exp_cmd.size() + exp_dat.size(), 0);
      finish_run();
   end
endmodule